// File: doc/BRIEF.md
# Per-Class Queue Admission With Congestion Marking

This block sits in front of a set of egress class queues that share a single buffer pool. It tracks how full each class queue is and how full the pool is. For every enqueue request it returns one of three outcomes: accept the packet, accept it with a congestion mark, or refuse it. Each outcome carries a reason code. Dequeue events return the occupancy they name to both the class and the pool, so the occupancy figures follow the real queues.

Software sets a mark level and a hard limit for each class, and one limit for the whole pool, through a small write port. For each class the block keeps the current depth, a high-water mark, a mark counter and a drop counter. Software picks one class on a select input and reads these figures. A clear pulse resets the selected class's high-water mark and counters. This lets software check every mark and drop against the configured levels, and shows short bursts that an average would hide.

Top module: `ecn_qadmit`

## Requirements
- R1: While reset is asserted and after it is released, every class depth, high-water mark, mark counter and drop counter reads zero, and dec_valid is low.
- R2: A request presented on one rising edge gives dec_valid high with dec_code and dec_cls on the next edge. The codes are 00 accept, 01 accept with mark, 10 refused by the class limit, 11 refused by the pool limit. dec_valid is low after any edge with no request.
- R3: A packet is marked (01) when it carries the congestion-capable flag, when its class depth after acceptance would be strictly above the class mark level, and when neither limit is exceeded. The packet is accepted, so depth and pool grow by its length.
- R4: A packet without the congestion-capable flag that lands in the mark region is accepted with code 00 and does not increment the mark counter.
- R5: When class depth plus the packet length would exceed the class limit, the packet is refused with code 10 and the class depth does not change. This check takes priority over the pool check.
- R6: When the class limit passes but pool occupancy plus the packet length would exceed the pool limit, the packet is refused with code 11, whatever the class's own mark level. Reaching a limit exactly is accepted.
- R7: A dequeue lowers the named class depth, and the pool, by its length in the same edge, saturating at zero. An enqueue and a dequeue on the same class in one cycle are judged against the depth after the dequeue.
- R8: Each class high-water mark holds the largest depth reached since the last clear. On a clear it takes the class's depth after that edge.
- R9: Each class counts its marks, and its refusals of either kind, in separate counters that stop at all ones instead of wrapping.
- R10: stat_clr affects only the class on stat_cls. If a mark or drop occurs in the same edge, it is counted on top of the cleared value.
- R11: A write with cfg_sel 0 sets the class mark level, 1 sets the class limit, and 2 sets the pool limit. cfg_sel 3 changes nothing. After reset every level reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 2 | Field to write: 0 mark level, 1 class limit, 2 pool limit |
| cfg_cls | input | CLS_W | Class for a per-class write |
| cfg_data | input | DEPTH_W | Value written |
| enq_valid | input | 1 | Enqueue request |
| enq_cls | input | CLS_W | Class of the request |
| enq_len | input | LEN_W | Packet length in buffer units |
| enq_ect | input | 1 | Packet may be congestion-marked |
| deq_valid | input | 1 | Dequeue event |
| deq_cls | input | CLS_W | Class of the dequeue |
| deq_len | input | LEN_W | Length released |
| dec_valid | output | 1 | Decision present |
| dec_code | output | 2 | Decision reason code |
| dec_cls | output | CLS_W | Class the decision belongs to |
| stat_cls | input | CLS_W | Class shown on the obs outputs |
| stat_clr | input | 1 | Clear high-water mark and counters of stat_cls |
| obs_depth | output | DEPTH_W | Depth of the selected class |
| obs_hiwm | output | DEPTH_W | High-water mark of the selected class |
| obs_marks | output | CNT_W | Mark counter of the selected class |
| obs_drops | output | CNT_W | Drop counter of the selected class |

## Verification
Decisions are registered, so a request driven before edge k has its code on dec_code from edge k until the next edge. The bench drives on the falling edge and reads the decision on the following falling edge. Depth, high-water mark and counters also change on edge k. They reach the obs outputs through a combinational select, so the bench reads them on that same falling edge, or after changing stat_cls and waiting a short delay with no clock edge in between. The same-cycle ordering cases are built so that the two possible orderings give different codes or counts.

// File: rtl/ecn_qadmit_pkg.sv
package ecn_qadmit_pkg;

  typedef enum logic [1:0] {
    VERDICT_PASS       = 2'b00,
    VERDICT_MARK       = 2'b01,
    VERDICT_CLASS_DROP = 2'b10,
    VERDICT_POOL_DROP  = 2'b11
  } verdict_e;

  typedef enum logic [1:0] {
    CFG_MARK_LVL  = 2'd0,
    CFG_CLASS_LIM = 2'd1,
    CFG_POOL_LIM  = 2'd2,
    CFG_UNUSED    = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/ecn_qadmit_cfg.sv
module ecn_qadmit_cfg
  import ecn_qadmit_pkg::*;
#(
  parameter int NCLS    = 4,
  parameter int DEPTH_W = 14,
  localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [CLS_W-1:0]   wr_cls,
  input  logic [DEPTH_W-1:0] wr_data,
  output logic [DEPTH_W-1:0] mark_lvl [NCLS],
  output logic [DEPTH_W-1:0] class_lim [NCLS],
  output logic [DEPTH_W-1:0] pool_lim
);

  logic pool_we;
  assign pool_we = wr_en && (cfg_sel_e'(wr_sel) == CFG_POOL_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pool_lim <= '1;
    end else if (pool_we) begin
      pool_lim <= wr_data;
    end
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    logic mark_we;
    logic lim_we;

    assign mark_we = wr_en && (wr_cls == CLS_W'(g)) &&
                     (cfg_sel_e'(wr_sel) == CFG_MARK_LVL);
    assign lim_we  = wr_en && (wr_cls == CLS_W'(g)) &&
                     (cfg_sel_e'(wr_sel) == CFG_CLASS_LIM);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mark_lvl[g] <= '1;
      end else if (mark_we) begin
        mark_lvl[g] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        class_lim[g] <= '1;
      end else if (lim_we) begin
        class_lim[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/ecn_qadmit_lane.sv
module ecn_qadmit_lane #(
  parameter int DEPTH_W = 14,
  parameter int LEN_W   = 10,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               deq_hit,
  input  logic [LEN_W-1:0]   deq_len,
  input  logic               add_en,
  input  logic [LEN_W-1:0]   add_len,
  input  logic               mark_inc,
  input  logic               drop_inc,
  input  logic               clr,
  output logic [DEPTH_W-1:0] eff_depth,
  output logic [DEPTH_W-1:0] freed,
  output logic [DEPTH_W-1:0] depth,
  output logic [DEPTH_W-1:0] hiwm,
  output logic [CNT_W-1:0]   marks,
  output logic [CNT_W-1:0]   drops
);

  localparam int PAD_W = DEPTH_W - LEN_W;

  logic [DEPTH_W-1:0] deq_ext, add_ext;
  logic [DEPTH_W-1:0] depth_d, hiwm_d;
  logic [CNT_W-1:0]   mark_base, drop_base, marks_d, drops_d;
  logic               upd_en;

  assign deq_ext = {{PAD_W{1'b0}}, deq_len};
  assign add_ext = {{PAD_W{1'b0}}, add_len};

  always_comb begin
    freed = '0;
    if (deq_hit) begin
      freed = (deq_ext > depth) ? depth : deq_ext;
    end
    eff_depth = depth - freed;
    depth_d   = add_en ? (eff_depth + add_ext) : eff_depth;

    if (clr) begin
      hiwm_d = depth_d;
    end else begin
      hiwm_d = (depth_d > hiwm) ? depth_d : hiwm;
    end

    mark_base = clr ? '0 : marks;
    drop_base = clr ? '0 : drops;
    marks_d   = (mark_inc && (mark_base != '1)) ? mark_base + 1'b1 : mark_base;
    drops_d   = (drop_inc && (drop_base != '1)) ? drop_base + 1'b1 : drop_base;

    upd_en = deq_hit | add_en | mark_inc | drop_inc | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      hiwm  <= '0;
      marks <= '0;
      drops <= '0;
    end else if (upd_en) begin
      depth <= depth_d;
      hiwm  <= hiwm_d;
      marks <= marks_d;
      drops <= drops_d;
    end
  end

endmodule

// File: rtl/ecn_qadmit_judge.sv
module ecn_qadmit_judge
  import ecn_qadmit_pkg::*;
#(
  parameter int DEPTH_W = 14,
  parameter int LEN_W   = 10
) (
  input  logic [DEPTH_W-1:0] eff_depth,
  input  logic [DEPTH_W-1:0] pool_eff,
  input  logic [LEN_W-1:0]   len,
  input  logic               ect,
  input  logic [DEPTH_W-1:0] mark_lvl,
  input  logic [DEPTH_W-1:0] class_lim,
  input  logic [DEPTH_W-1:0] pool_lim,
  output verdict_e           verdict
);

  localparam int SUM_W = DEPTH_W + 1;

  logic [SUM_W-1:0] len_ext, cls_after, pool_after;

  assign len_ext    = {{(SUM_W - LEN_W){1'b0}}, len};
  assign cls_after  = {1'b0, eff_depth} + len_ext;
  assign pool_after = {1'b0, pool_eff} + len_ext;

  always_comb begin
    if (cls_after > {1'b0, class_lim}) begin
      verdict = VERDICT_CLASS_DROP;
    end else if (pool_after > {1'b0, pool_lim}) begin
      verdict = VERDICT_POOL_DROP;
    end else if (ect && (cls_after > {1'b0, mark_lvl})) begin
      verdict = VERDICT_MARK;
    end else begin
      verdict = VERDICT_PASS;
    end
  end

endmodule

// File: rtl/ecn_qadmit.sv
module ecn_qadmit
  import ecn_qadmit_pkg::*;
#(
  parameter int NCLS    = 4,
  parameter int LEN_W   = 10,
  parameter int DEPTH_W = 14,
  parameter int CNT_W   = 16,
  localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [CLS_W-1:0]   cfg_cls,
  input  logic [DEPTH_W-1:0] cfg_data,
  input  logic               enq_valid,
  input  logic [CLS_W-1:0]   enq_cls,
  input  logic [LEN_W-1:0]   enq_len,
  input  logic               enq_ect,
  input  logic               deq_valid,
  input  logic [CLS_W-1:0]   deq_cls,
  input  logic [LEN_W-1:0]   deq_len,
  output logic               dec_valid,
  output logic [1:0]         dec_code,
  output logic [CLS_W-1:0]   dec_cls,
  input  logic [CLS_W-1:0]   stat_cls,
  input  logic               stat_clr,
  output logic [DEPTH_W-1:0] obs_depth,
  output logic [DEPTH_W-1:0] obs_hiwm,
  output logic [CNT_W-1:0]   obs_marks,
  output logic [CNT_W-1:0]   obs_drops
);

  logic [DEPTH_W-1:0] mark_lvl  [NCLS];
  logic [DEPTH_W-1:0] class_lim [NCLS];
  logic [DEPTH_W-1:0] pool_lim;

  logic [DEPTH_W-1:0] eff_depth [NCLS];
  logic [DEPTH_W-1:0] freed     [NCLS];
  logic [DEPTH_W-1:0] depth     [NCLS];
  logic [DEPTH_W-1:0] hiwm      [NCLS];
  logic [CNT_W-1:0]   marks     [NCLS];
  logic [CNT_W-1:0]   drops     [NCLS];

  logic [DEPTH_W-1:0] pool_used, pool_eff, pool_d;
  logic [DEPTH_W-1:0] freed_sel;
  verdict_e           verdict;
  logic               accept;
  logic               pool_en;

  ecn_qadmit_cfg #(
    .NCLS    (NCLS),
    .DEPTH_W (DEPTH_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_sel    (cfg_sel),
    .wr_cls    (cfg_cls),
    .wr_data   (cfg_data),
    .mark_lvl  (mark_lvl),
    .class_lim (class_lim),
    .pool_lim  (pool_lim)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_lane
    logic hit_enq;
    assign hit_enq = enq_valid && (enq_cls == CLS_W'(g));

    ecn_qadmit_lane #(
      .DEPTH_W (DEPTH_W),
      .LEN_W   (LEN_W),
      .CNT_W   (CNT_W)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .deq_hit   (deq_valid && (deq_cls == CLS_W'(g))),
      .deq_len   (deq_len),
      .add_en    (hit_enq && accept),
      .add_len   (enq_len),
      .mark_inc  (hit_enq && (verdict == VERDICT_MARK)),
      .drop_inc  (hit_enq && verdict[1]),
      .clr       (stat_clr && (stat_cls == CLS_W'(g))),
      .eff_depth (eff_depth[g]),
      .freed     (freed[g]),
      .depth     (depth[g]),
      .hiwm      (hiwm[g]),
      .marks     (marks[g]),
      .drops     (drops[g])
    );
  end

  // Only one lane can release per cycle; the pool gives back exactly that.
  assign freed_sel = deq_valid ? freed[deq_cls] : '0;
  assign pool_eff  = pool_used - freed_sel;

  ecn_qadmit_judge #(
    .DEPTH_W (DEPTH_W),
    .LEN_W   (LEN_W)
  ) u_judge (
    .eff_depth (eff_depth[enq_cls]),
    .pool_eff  (pool_eff),
    .len       (enq_len),
    .ect       (enq_ect),
    .mark_lvl  (mark_lvl[enq_cls]),
    .class_lim (class_lim[enq_cls]),
    .pool_lim  (pool_lim),
    .verdict   (verdict)
  );

  assign accept = !verdict[1];

  always_comb begin
    pool_d  = pool_eff;
    if (enq_valid && accept) begin
      pool_d = pool_eff + {{(DEPTH_W - LEN_W){1'b0}}, enq_len};
    end
    pool_en = deq_valid | enq_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pool_used <= '0;
    end else if (pool_en) begin
      pool_used <= pool_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= enq_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_code <= '0;
      dec_cls  <= '0;
    end else if (enq_valid) begin
      dec_code <= verdict;
      dec_cls  <= enq_cls;
    end
  end

  assign obs_depth = depth[stat_cls];
  assign obs_hiwm  = hiwm[stat_cls];
  assign obs_marks = marks[stat_cls];
  assign obs_drops = drops[stat_cls];

endmodule

// File: rtl/ecn_qadmit_chk.sv
module ecn_qadmit_chk #(
  parameter int DEPTH_W = 14,
  parameter int CNT_W   = 16,
  parameter int CLS_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enq_valid,
  input logic               enq_ect,
  input logic               dec_valid,
  input logic [1:0]         dec_code,
  input logic [CLS_W-1:0]   stat_cls,
  input logic               stat_clr,
  input logic [DEPTH_W-1:0] obs_depth,
  input logic [DEPTH_W-1:0] obs_hiwm,
  input logic [CNT_W-1:0]   obs_marks,
  input logic [CNT_W-1:0]   obs_drops
);

  // R2
  dec_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid |=> dec_valid);

  // R2
  dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_valid |=> !dec_valid);

  // R4
  no_mark_without_ect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && !enq_ect) |=> (dec_code != 2'b01));

  // R8
  hiwm_covers_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    obs_hiwm >= obs_depth);

  // R9
  marks_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> (!$stable(stat_cls) || (obs_marks >= $past(obs_marks))));

  // R9
  drops_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> (!$stable(stat_cls) || (obs_drops >= $past(obs_drops))));

endmodule

bind ecn_qadmit ecn_qadmit_chk #(
  .DEPTH_W (DEPTH_W),
  .CNT_W   (CNT_W),
  .CLS_W   (CLS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enq_valid (enq_valid),
  .enq_ect   (enq_ect),
  .dec_valid (dec_valid),
  .dec_code  (dec_code),
  .stat_cls  (stat_cls),
  .stat_clr  (stat_clr),
  .obs_depth (obs_depth),
  .obs_hiwm  (obs_hiwm),
  .obs_marks (obs_marks),
  .obs_drops (obs_drops)
);

// File: tb/tb_ecn_qadmit.sv
module tb_ecn_qadmit;

  localparam int NCLS    = 4;
  localparam int LEN_W   = 10;
  localparam int DEPTH_W = 12;
  localparam int CNT_W   = 4;
  localparam int CLS_W   = 2;
  localparam int VEC_N   = 11;

  logic               clk;
  logic               rst_n;
  logic               cfg_we;
  logic [1:0]         cfg_sel;
  logic [CLS_W-1:0]   cfg_cls;
  logic [DEPTH_W-1:0] cfg_data;
  logic               enq_valid;
  logic [CLS_W-1:0]   enq_cls;
  logic [LEN_W-1:0]   enq_len;
  logic               enq_ect;
  logic               deq_valid;
  logic [CLS_W-1:0]   deq_cls;
  logic [LEN_W-1:0]   deq_len;
  logic               dec_valid;
  logic [1:0]         dec_code;
  logic [CLS_W-1:0]   dec_cls;
  logic [CLS_W-1:0]   stat_cls;
  logic               stat_clr;
  logic [DEPTH_W-1:0] obs_depth;
  logic [DEPTH_W-1:0] obs_hiwm;
  logic [CNT_W-1:0]   obs_marks;
  logic [CNT_W-1:0]   obs_drops;

  int n_chk;
  int n_bad;
  bit done;

  // {cls[1:0], len[9:0], ect, code[1:0], depth after[11:0]}
  localparam logic [26:0] VEC [VEC_N] = '{
    {2'd0, 10'd60,  1'b1, 2'b00, 12'd60},
    {2'd0, 10'd40,  1'b1, 2'b00, 12'd100},
    {2'd0, 10'd10,  1'b1, 2'b01, 12'd110},
    {2'd0, 10'd20,  1'b0, 2'b00, 12'd130},
    {2'd0, 10'd80,  1'b1, 2'b10, 12'd130},
    {2'd0, 10'd70,  1'b1, 2'b01, 12'd200},
    {2'd1, 10'd40,  1'b1, 2'b00, 12'd40},
    {2'd1, 10'd100, 1'b1, 2'b01, 12'd140},
    {2'd2, 10'd100, 1'b1, 2'b11, 12'd0},
    {2'd2, 10'd60,  1'b0, 2'b00, 12'd60},
    {2'd1, 10'd200, 1'b1, 2'b10, 12'd140}
  };

  ecn_qadmit #(
    .NCLS    (NCLS),
    .LEN_W   (LEN_W),
    .DEPTH_W (DEPTH_W),
    .CNT_W   (CNT_W)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_cls   (cfg_cls),
    .cfg_data  (cfg_data),
    .enq_valid (enq_valid),
    .enq_cls   (enq_cls),
    .enq_len   (enq_len),
    .enq_ect   (enq_ect),
    .deq_valid (deq_valid),
    .deq_cls   (deq_cls),
    .deq_len   (deq_len),
    .dec_valid (dec_valid),
    .dec_code  (dec_code),
    .dec_cls   (dec_cls),
    .stat_cls  (stat_cls),
    .stat_clr  (stat_clr),
    .obs_depth (obs_depth),
    .obs_hiwm  (obs_hiwm),
    .obs_marks (obs_marks),
    .obs_drops (obs_drops)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic look(input int cls);
    stat_cls = CLS_W'(cls);
    #1;
  endtask

  task automatic cfg_write(input int sel, input int cls, input int val);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_sel  = 2'(sel);
    cfg_cls  = CLS_W'(cls);
    cfg_data = DEPTH_W'(val);
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  // Request on one edge; decision read on the falling edge after it.
  task automatic enq(input int cls, input int len, input bit ect,
                     input bit with_deq, input int dcls, input int dlen,
                     input bit clr);
    @(negedge clk);
    enq_valid = 1'b1;
    enq_cls   = CLS_W'(cls);
    enq_len   = LEN_W'(len);
    enq_ect   = ect;
    deq_valid = with_deq;
    deq_cls   = CLS_W'(dcls);
    deq_len   = LEN_W'(dlen);
    stat_clr  = clr;
    if (clr) stat_cls = CLS_W'(cls);
    @(negedge clk);
    enq_valid = 1'b0;
    deq_valid = 1'b0;
    stat_clr  = 1'b0;
  endtask

  task automatic deq(input int cls, input int len);
    @(negedge clk);
    deq_valid = 1'b1;
    deq_cls   = CLS_W'(cls);
    deq_len   = LEN_W'(len);
    @(negedge clk);
    deq_valid = 1'b0;
  endtask

  task automatic clear(input int cls);
    @(negedge clk);
    stat_cls = CLS_W'(cls);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_cls = '0; cfg_data = '0;
    enq_valid = 1'b0; enq_cls = '0; enq_len = '0; enq_ect = 1'b0;
    deq_valid = 1'b0; deq_cls = '0; deq_len = '0;
    stat_cls = '0; stat_clr = 1'b0;
    n_chk = 0; n_bad = 0; done = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: clean state after reset
    check("R1 dec_valid", int'(dec_valid), 0);
    for (int c = 0; c < NCLS; c++) begin
      look(c);
      check("R1 depth", int'(obs_depth), 0);
      check("R1 hiwm", int'(obs_hiwm), 0);
      check("R1 marks", int'(obs_marks), 0);
      check("R1 drops", int'(obs_drops), 0);
    end

    // R11: levels for the table
    cfg_write(0, 0, 100);
    cfg_write(1, 0, 200);
    cfg_write(0, 1, 50);
    cfg_write(1, 1, 300);
    cfg_write(2, 0, 400);

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < VEC_N; i++) begin
      enq(int'(VEC[i][26:25]), int'(VEC[i][24:15]), VEC[i][14], 1'b0, 0, 0, 1'b0);
      check("R2 dec_valid", int'(dec_valid), 1);
      check("R2 dec_cls", int'(dec_cls), int'(VEC[i][26:25]));
      check("R3/R4/R5/R6 code", int'(dec_code), int'(VEC[i][13:12]));
      look(int'(VEC[i][26:25]));
      check("R5 depth", int'(obs_depth), int'(VEC[i][11:0]));
    end
    @(negedge clk);
    check("R2 idle", int'(dec_valid), 0);

    // R8 R9 evidence after the table
    look(0);
    check("R8 hiwm c0", int'(obs_hiwm), 200);
    check("R9 marks c0", int'(obs_marks), 2);
    check("R9 drops c0", int'(obs_drops), 1);
    look(1);
    check("R9 marks c1", int'(obs_marks), 1);
    check("R9 drops c1", int'(obs_drops), 1);
    look(2);
    check("R4 marks c2", int'(obs_marks), 0);
    check("R6 drops c2", int'(obs_drops), 1);
    check("R8 hiwm c2", int'(obs_hiwm), 60);

    // R7: dequeue
    deq(0, 50);
    look(0);
    check("R7 deq depth", int'(obs_depth), 150);
    check("R8 hiwm held", int'(obs_hiwm), 200);

    // R7: same-cycle enq/deq on class 0, dequeue first (else class drop)
    enq(0, 60, 1'b1, 1'b1, 0, 20, 1'b0);
    check("R7 same-cycle code", int'(dec_code), 1);
    look(0);
    check("R7 same-cycle depth", int'(obs_depth), 190);

    // R7: dequeue below zero saturates
    deq(3, 5);
    look(3);
    check("R7 underflow", int'(obs_depth), 0);

    // R10: clear only class 0
    clear(0);
    look(0);
    check("R10 marks cleared", int'(obs_marks), 0);
    check("R10 drops cleared", int'(obs_drops), 0);
    check("R8 hiwm to depth", int'(obs_hiwm), 190);
    look(1);
    check("R10 other class kept", int'(obs_marks), 1);

    // R10: clear together with a mark in the same edge
    enq(0, 5, 1'b1, 1'b0, 0, 0, 1'b1);
    check("R10 code", int'(dec_code), 1);
    look(0);
    check("R10 mark after clear", int'(obs_marks), 1);
    check("R8 hiwm after clear", int'(obs_hiwm), 195);

    // R11: cfg_sel 3 ignored; pool limit raised
    cfg_write(3, 1, 0);
    cfg_write(2, 0, 1000);
    enq(1, 10, 1'b1, 1'b0, 0, 0, 1'b0);
    check("R11 sel3 ignored", int'(dec_code), 1);
    look(1);
    check("R11 depth", int'(obs_depth), 150);
    check("R9 marks c1", int'(obs_marks), 2);

    // R9: saturation at 15
    for (int k = 0; k < 14; k++) begin
      enq(1, 1, 1'b1, 1'b0, 0, 0, 1'b0);
    end
    look(1);
    check("R9 saturate", int'(obs_marks), 15);
    check("R9 drops kept", int'(obs_drops), 1);
    check("R3 depth c1", int'(obs_depth), 164);

    // R11: per-class mark level written to zero
    cfg_write(0, 3, 0);
    enq(3, 1, 1'b1, 1'b0, 0, 0, 1'b0);
    check("R11 mark lvl c3", int'(dec_code), 1);
    check("R2 dec_cls c3", int'(dec_cls), 3);
    look(3);
    check("R3 depth c3", int'(obs_depth), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule